// File: doc/BRIEF.md
# Set/Clear Aliased Transceiver Control Register File

This block holds the byte-wide control and status registers of a USB transceiver. A link controller reaches them through a simple synchronous access port. The port carries an address, a flag that selects the extended address space, write data, a write strobe, a read strobe and registered read data with a one-cycle valid pulse. Each writable register appears at three consecutive addresses. A write to the first address overwrites the register. A write to the second ORs the data byte into it. A write to the third clears every bit that is set in the data byte. Software can therefore change single control bits without a read-modify-write sequence.

The identification bytes, the live interrupt-source status and the line-state debug byte are read-only. An interrupt latch collects edges of the source inputs in the directions that the two edge-enable registers allow, and a read of the latch clears it. With the extended flag raised, the access uses a full 8-bit address. Extended addresses 00h to 3Fh reach the same registers as the immediate space, and all higher extended addresses are reserved.

Reads pass through a two-state sequencer. ACC_IDLE is the resting state. A read strobe moves it to ACC_RESP (the IDLE_TO_RESP transition), where read data is valid for one cycle. A further read strobe keeps it in ACC_RESP (RESP_TO_RESP), and a cycle with no strobe returns it to ACC_IDLE (RESP_TO_IDLE). With no strobe it stays in ACC_IDLE (IDLE_HOLD).

Top module: `usbphy_regs`

## Requirements
- R1: After reset, every control, enable and scratch register reads 00h, and addresses 00h, 01h, 02h and 03h read the low and high bytes of the VENDOR_ID parameter and then of the PRODUCT_ID parameter.
- R2: A write to the base address of a triple overwrites the register with the data byte. The bases are function 04h, interface 07h, OTG 0Ah, rise-enable 0Dh, fall-enable 10h, scratch 16h and power 3Dh.
- R3: A write to base+1 ORs the data byte into the register.
- R4: A write to base+2 clears each register bit whose data bit is 1 and keeps the others.
- R5: A read of any of the three addresses of a triple returns the register value.
- R6: Addresses 00h–03h and 13h–15h ignore writes. 13h returns the source inputs with source i in bit i and upper bits 0. 15h returns the line-state input in its low bits.
- R7: With the extended flag low, addresses 19h–2Eh, 2Fh (the escape code) and 30h–3Ch read 00h and ignore writes. Only the low 6 address bits are used.
- R8: With the extended flag high, addresses 00h–3Fh reach the same registers as the immediate space, and addresses 40h–FFh read 00h and ignore writes.
- R9: Latch bit i sets when source i rises while rise-enable bit i is 1, or falls while fall-enable bit i is 1. An edge in a disabled direction sets nothing.
- R10: A read of 14h returns the latch and clears it. An event detected in the same cycle as that read leaves its bit set.
- R11: rd_data and rd_valid update one cycle after a read strobe. rd_valid is high only in cycles that follow a strobe, and rd_data holds until the next read.
- R12: A read and a write to the same register in one cycle return the value from before the write.
- R13: The func_ctrl, intf_ctrl, otg_ctrl and pwr_ctrl outputs always equal the function, interface, OTG and power registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_addr | input | 8 | Access address (low 6 bits used unless acc_ext) |
| acc_ext | input | 1 | Selects the extended 8-bit address space |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data or mask |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Registered read data |
| rd_valid | output | 1 | High in the cycle after a read strobe |
| line_state | input | LS_W | Live line-state bits shown at 15h |
| irq_src | input | NUM_SRC | Live interrupt-source levels |
| func_ctrl | output | 8 | Function control register |
| intf_ctrl | output | 8 | Interface control register |
| otg_ctrl | output | 8 | OTG control register |
| pwr_ctrl | output | 8 | Power control register |

## Verification
Two functions can act on the same state in one cycle. A read of the latch clears it, while a source edge sets it. The bench drives a source rise together with a read strobe at 14h. It expects 00h from that read and the bit back on the following read. A second collision, a write and a read of the same register in one cycle, is judged by the read returning the old value and a later read returning the new one.

// File: rtl/usbphy_regs_pkg.sv
package usbphy_regs_pkg;

    localparam int REG_W      = 8;
    localparam int ADDR_W     = 8;
    localparam int LOC_W      = 6;
    localparam int NUM_TRIPLE = 7;

    // triple register indices
    localparam int TR_FUNC    = 0;
    localparam int TR_INTF    = 1;
    localparam int TR_OTG     = 2;
    localparam int TR_RISE    = 3;
    localparam int TR_FALL    = 4;
    localparam int TR_SCRATCH = 5;
    localparam int TR_PWR     = 6;

    localparam logic [LOC_W-1:0] LOC_VID_LO   = 6'h00;
    localparam logic [LOC_W-1:0] LOC_VID_HI   = 6'h01;
    localparam logic [LOC_W-1:0] LOC_PID_LO   = 6'h02;
    localparam logic [LOC_W-1:0] LOC_PID_HI   = 6'h03;
    localparam logic [LOC_W-1:0] LOC_IRQ_STAT = 6'h13;
    localparam logic [LOC_W-1:0] LOC_IRQ_LAT  = 6'h14;
    localparam logic [LOC_W-1:0] LOC_LINE_DBG = 6'h15;
    localparam logic [LOC_W-1:0] LOC_ESCAPE   = 6'h2F;

    typedef enum logic [1:0] {
        ALIAS_WRITE = 2'd0,
        ALIAS_SET   = 2'd1,
        ALIAS_CLEAR = 2'd2,
        ALIAS_NONE  = 2'd3
    } alias_op_t;

    typedef enum logic [3:0] {
        RS_NONE,
        RS_VID_LO,
        RS_VID_HI,
        RS_PID_LO,
        RS_PID_HI,
        RS_TRIPLE,
        RS_IRQ_STAT,
        RS_IRQ_LAT,
        RS_LINE_DBG
    } rsel_t;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_t;

    // base location of each triple; the three aliases follow it
    function automatic logic [LOC_W-1:0] triple_base(input int idx);
        logic [LOC_W-1:0] b;
        case (idx)
            TR_FUNC:    b = 6'h04;
            TR_INTF:    b = 6'h07;
            TR_OTG:     b = 6'h0A;
            TR_RISE:    b = 6'h0D;
            TR_FALL:    b = 6'h10;
            TR_SCRATCH: b = 6'h16;
            default:    b = 6'h3D;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/usbphy_regs_decode.sv
module usbphy_regs_decode
    import usbphy_regs_pkg::*;
(
    input  logic [ADDR_W-1:0]     acc_addr,
    input  logic                  acc_ext,
    output logic [NUM_TRIPLE-1:0] tr_hit,
    output alias_op_t             tr_op,
    output rsel_t                 rsel
);

    logic [LOC_W-1:0] loc;
    logic             reachable;

    always_comb begin
        loc       = acc_addr[LOC_W-1:0];
        reachable = !acc_ext || (acc_addr[ADDR_W-1:LOC_W] == '0);
        if (loc == LOC_ESCAPE) begin
            reachable = 1'b0;
        end
    end

    always_comb begin
        logic [LOC_W-1:0] diff;
        tr_hit = '0;
        tr_op  = ALIAS_NONE;
        for (int i = 0; i < NUM_TRIPLE; i++) begin
            diff = loc - triple_base(i);
            if (reachable && (diff < 6'd3)) begin
                tr_hit[i] = 1'b1;
                unique case (diff[1:0])
                    2'd0:    tr_op = ALIAS_WRITE;
                    2'd1:    tr_op = ALIAS_SET;
                    default: tr_op = ALIAS_CLEAR;
                endcase
            end
        end
    end

    always_comb begin
        rsel = RS_NONE;
        if (reachable) begin
            if (|tr_hit) begin
                rsel = RS_TRIPLE;
            end else begin
                case (loc)
                    LOC_VID_LO:   rsel = RS_VID_LO;
                    LOC_VID_HI:   rsel = RS_VID_HI;
                    LOC_PID_LO:   rsel = RS_PID_LO;
                    LOC_PID_HI:   rsel = RS_PID_HI;
                    LOC_IRQ_STAT: rsel = RS_IRQ_STAT;
                    LOC_IRQ_LAT:  rsel = RS_IRQ_LAT;
                    LOC_LINE_DBG: rsel = RS_LINE_DBG;
                    default:      rsel = RS_NONE;
                endcase
            end
        end
    end

endmodule

// File: rtl/usbphy_regs_alias_reg.sv
module usbphy_regs_alias_reg
    import usbphy_regs_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  alias_op_t    op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (we) begin
            unique case (op)
                ALIAS_WRITE: q <= wdata;
                ALIAS_SET:   q <= q | wdata;
                ALIAS_CLEAR: q <= q & ~wdata;
                default:     q <= q;
            endcase
        end
    end

endmodule

// File: rtl/usbphy_regs_irq_latch.sv
module usbphy_regs_irq_latch #(
    parameter int NUM_SRC = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src,
    input  logic [NUM_SRC-1:0] rise_en,
    input  logic [NUM_SRC-1:0] fall_en,
    input  logic               rd_clr,
    output logic [NUM_SRC-1:0] latch_q
);

    logic [NUM_SRC-1:0] src_q;
    logic [NUM_SRC-1:0] evt;

    always_comb begin
        evt = (src & ~src_q & rise_en) | (~src & src_q & fall_en);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            src_q   <= '0;
            latch_q <= '0;
        end else begin
            src_q   <= src;
            // a fresh event outranks the clear-on-read
            latch_q <= (latch_q & ~{NUM_SRC{rd_clr}}) | evt;
        end
    end

endmodule

// File: rtl/usbphy_regs.sv
module usbphy_regs
    import usbphy_regs_pkg::*;
#(
    parameter int          NUM_SRC    = 5,
    parameter int          LS_W       = 2,
    parameter logic [15:0] VENDOR_ID  = 16'h1A2B,
    parameter logic [15:0] PRODUCT_ID = 16'h3C4D
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [7:0]         acc_addr,
    input  logic               acc_ext,
    input  logic               wr_en,
    input  logic [7:0]         wr_data,
    input  logic               rd_en,
    output logic [7:0]         rd_data,
    output logic               rd_valid,
    input  logic [LS_W-1:0]    line_state,
    input  logic [NUM_SRC-1:0] irq_src,
    output logic [7:0]         func_ctrl,
    output logic [7:0]         intf_ctrl,
    output logic [7:0]         otg_ctrl,
    output logic [7:0]         pwr_ctrl
);

    logic [NUM_TRIPLE-1:0] tr_hit;
    alias_op_t             tr_op;
    rsel_t                 rsel;
    logic [REG_W-1:0]      tr_q [NUM_TRIPLE];
    logic [NUM_SRC-1:0]    irq_latch_q;
    logic [REG_W-1:0]      rd_mux;
    logic [REG_W-1:0]      rd_data_q;
    logic                  lat_rd_clr;
    acc_state_t            state_q;
    acc_state_t            state_d;

    usbphy_regs_decode u_decode (
        .acc_addr (acc_addr),
        .acc_ext  (acc_ext),
        .tr_hit   (tr_hit),
        .tr_op    (tr_op),
        .rsel     (rsel)
    );

    for (genvar g = 0; g < NUM_TRIPLE; g++) begin : g_triple
        usbphy_regs_alias_reg #(.W(REG_W)) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_en && tr_hit[g]),
            .op    (tr_op),
            .wdata (wr_data),
            .q     (tr_q[g])
        );
    end

    assign lat_rd_clr = rd_en && (rsel == RS_IRQ_LAT);

    usbphy_regs_irq_latch #(.NUM_SRC(NUM_SRC)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .src     (irq_src),
        .rise_en (tr_q[TR_RISE][NUM_SRC-1:0]),
        .fall_en (tr_q[TR_FALL][NUM_SRC-1:0]),
        .rd_clr  (lat_rd_clr),
        .latch_q (irq_latch_q)
    );

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        unique case (rsel)
            RS_VID_LO:   rd_mux = VENDOR_ID[7:0];
            RS_VID_HI:   rd_mux = VENDOR_ID[15:8];
            RS_PID_LO:   rd_mux = PRODUCT_ID[7:0];
            RS_PID_HI:   rd_mux = PRODUCT_ID[15:8];
            RS_TRIPLE: begin
                for (int i = 0; i < NUM_TRIPLE; i++) begin
                    rd_mux = rd_mux | (tr_q[i] & {REG_W{tr_hit[i]}});
                end
            end
            RS_IRQ_STAT: rd_mux[NUM_SRC-1:0] = irq_src;
            RS_IRQ_LAT:  rd_mux[NUM_SRC-1:0] = irq_latch_q;
            RS_LINE_DBG: rd_mux[LS_W-1:0]    = line_state;
            default:     rd_mux = '0;
        endcase
    end

    // access sequencer: state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ACC_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // access sequencer: next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACC_IDLE: state_d = rd_en ? ACC_RESP : ACC_IDLE;
            ACC_RESP: state_d = rd_en ? ACC_RESP : ACC_IDLE;
            default:  state_d = ACC_IDLE;
        endcase
    end

    // read data capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_q <= '0;
        end else if (rd_en) begin
            rd_data_q <= rd_mux;
        end
    end

    // outputs
    always_comb begin
        rd_valid  = (state_q == ACC_RESP);
        rd_data   = rd_data_q;
        func_ctrl = tr_q[TR_FUNC];
        intf_ctrl = tr_q[TR_INTF];
        otg_ctrl  = tr_q[TR_OTG];
        pwr_ctrl  = tr_q[TR_PWR];
    end

endmodule

// File: rtl/usbphy_regs_checker.sv
module usbphy_regs_checker #(
    parameter int NUM_SRC = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic [7:0]         acc_addr,
    input logic               acc_ext,
    input logic               wr_en,
    input logic [7:0]         wr_data,
    input logic               rd_en,
    input logic [7:0]         rd_data,
    input logic               rd_valid,
    input logic [NUM_SRC-1:0] irq_src,
    input logic [NUM_SRC-1:0] irq_latch_q,
    input logic [7:0]         func_ctrl,
    input logic [7:0]         intf_ctrl,
    input logic [7:0]         otg_ctrl,
    input logic [7:0]         pwr_ctrl
);

    a_r11_valid_after_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_valid);

    a_r11_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_valid);

    a_r2_base_overwrites: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !acc_ext && acc_addr == 8'h04) |=> (func_ctrl == $past(wr_data)));

    a_r3_set_ors: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !acc_ext && acc_addr == 8'h05)
        |=> (func_ctrl == ($past(func_ctrl) | $past(wr_data))));

    a_r4_clear_masks: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !acc_ext && acc_addr == 8'h06)
        |=> (func_ctrl == ($past(func_ctrl) & ~$past(wr_data))));

    a_r6_readonly_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !acc_ext && acc_addr[7:2] == 6'd0)
        |=> ($stable(func_ctrl) && $stable(intf_ctrl) && $stable(otg_ctrl) && $stable(pwr_ctrl)));

    a_r7_reserved_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !acc_ext && acc_addr[5:0] >= 6'h19 && acc_addr[5:0] <= 6'h3C)
        |=> ($stable(func_ctrl) && $stable(intf_ctrl) && $stable(otg_ctrl) && $stable(pwr_ctrl)));

    a_r7_reserved_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !acc_ext && acc_addr[5:0] >= 6'h19 && acc_addr[5:0] <= 6'h3C)
        |=> (rd_data == 8'h00));

    a_r8_ext_high_read: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && acc_ext && acc_addr[7:6] != 2'b00) |=> (rd_data == 8'h00));

    a_r10_latch_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !acc_ext && acc_addr[5:0] == 6'h14 && $stable(irq_src))
        |=> (irq_latch_q == '0));

endmodule

bind usbphy_regs usbphy_regs_checker #(.NUM_SRC(NUM_SRC)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_addr    (acc_addr),
    .acc_ext     (acc_ext),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid),
    .irq_src     (irq_src),
    .irq_latch_q (irq_latch_q),
    .func_ctrl   (func_ctrl),
    .intf_ctrl   (intf_ctrl),
    .otg_ctrl    (otg_ctrl),
    .pwr_ctrl    (pwr_ctrl)
);

// File: tb/usbphy_regs_test.sv
module usbphy_regs_test;

    localparam int          NSRC = 5;
    localparam logic [15:0] VID  = 16'h1A2B;
    localparam logic [15:0] PID  = 16'h3C4D;
    localparam int          NV   = 41;

    // {req[3:0], is_read, ext, addr[7:0], data[7:0], expect[7:0]}
    localparam logic [29:0] VEC [NV] = '{
        {4'd1,  1'b1, 1'b0, 8'h00, 8'h00, 8'h2B},  // R1 vendor low
        {4'd1,  1'b1, 1'b0, 8'h01, 8'h00, 8'h1A},  // R1 vendor high
        {4'd1,  1'b1, 1'b0, 8'h02, 8'h00, 8'h4D},  // R1 product low
        {4'd1,  1'b1, 1'b0, 8'h03, 8'h00, 8'h3C},  // R1 product high
        {4'd1,  1'b1, 1'b0, 8'h04, 8'h00, 8'h00},  // R1 function reset
        {4'd1,  1'b1, 1'b0, 8'h0D, 8'h00, 8'h00},  // R1 rise enable reset
        {4'd1,  1'b1, 1'b0, 8'h16, 8'h00, 8'h00},  // R1 scratch reset
        {4'd2,  1'b0, 1'b0, 8'h04, 8'hA5, 8'h00},  // R2 overwrite
        {4'd2,  1'b1, 1'b0, 8'h04, 8'h00, 8'hA5},
        {4'd5,  1'b1, 1'b0, 8'h05, 8'h00, 8'hA5},  // R5 set alias reads
        {4'd5,  1'b1, 1'b0, 8'h06, 8'h00, 8'hA5},  // R5 clear alias reads
        {4'd3,  1'b0, 1'b0, 8'h05, 8'h0A, 8'h00},  // R3 OR in
        {4'd3,  1'b1, 1'b0, 8'h04, 8'h00, 8'hAF},
        {4'd4,  1'b0, 1'b0, 8'h06, 8'h0F, 8'h00},  // R4 mask clear
        {4'd4,  1'b1, 1'b0, 8'h04, 8'h00, 8'hA0},
        {4'd2,  1'b0, 1'b0, 8'h07, 8'h3C, 8'h00},
        {4'd4,  1'b0, 1'b0, 8'h09, 8'h0C, 8'h00},
        {4'd4,  1'b1, 1'b0, 8'h08, 8'h00, 8'h30},
        {4'd3,  1'b0, 1'b0, 8'h0B, 8'h81, 8'h00},
        {4'd3,  1'b1, 1'b0, 8'h0A, 8'h00, 8'h81},
        {4'd2,  1'b0, 1'b0, 8'h16, 8'hFF, 8'h00},
        {4'd4,  1'b0, 1'b0, 8'h18, 8'hF0, 8'h00},
        {4'd5,  1'b1, 1'b0, 8'h17, 8'h00, 8'h0F},
        {4'd6,  1'b0, 1'b0, 8'h00, 8'h55, 8'h00},  // R6 id ignores writes
        {4'd6,  1'b1, 1'b0, 8'h00, 8'h00, 8'h2B},
        {4'd7,  1'b0, 1'b0, 8'h19, 8'h77, 8'h00},  // R7 reserved
        {4'd7,  1'b1, 1'b0, 8'h19, 8'h00, 8'h00},
        {4'd7,  1'b1, 1'b0, 8'h2E, 8'h00, 8'h00},
        {4'd7,  1'b0, 1'b0, 8'h2F, 8'h12, 8'h00},
        {4'd7,  1'b1, 1'b0, 8'h2F, 8'h00, 8'h00},
        {4'd7,  1'b1, 1'b0, 8'h30, 8'h00, 8'h00},
        {4'd7,  1'b1, 1'b0, 8'h3C, 8'h00, 8'h00},
        {4'd2,  1'b0, 1'b0, 8'h3D, 8'h11, 8'h00},  // power triple
        {4'd3,  1'b0, 1'b0, 8'h3E, 8'h02, 8'h00},
        {4'd5,  1'b1, 1'b0, 8'h3F, 8'h00, 8'h13},
        {4'd8,  1'b0, 1'b1, 8'h04, 8'h5A, 8'h00},  // R8 extended space
        {4'd8,  1'b1, 1'b0, 8'h04, 8'h00, 8'h5A},
        {4'd8,  1'b1, 1'b1, 8'h16, 8'h00, 8'h0F},
        {4'd8,  1'b0, 1'b1, 8'h40, 8'h99, 8'h00},
        {4'd8,  1'b1, 1'b1, 8'hFF, 8'h00, 8'h00},
        {4'd8,  1'b1, 1'b0, 8'h44, 8'h00, 8'h5A}   // R8 high bits ignored when ext low
    };

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [7:0]      acc_addr = '0;
    logic            acc_ext = 1'b0;
    logic            wr_en = 1'b0;
    logic [7:0]      wr_data = '0;
    logic            rd_en = 1'b0;
    logic [7:0]      rd_data;
    logic            rd_valid;
    logic [1:0]      line_state = '0;
    logic [NSRC-1:0] irq_src = '0;
    logic [7:0]      func_ctrl, intf_ctrl, otg_ctrl, pwr_ctrl;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    usbphy_regs #(
        .NUM_SRC(NSRC), .LS_W(2), .VENDOR_ID(VID), .PRODUCT_ID(PID)
    ) uut (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_ext(acc_ext),
        .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
        .rd_valid(rd_valid), .line_state(line_state), .irq_src(irq_src),
        .func_ctrl(func_ctrl), .intf_ctrl(intf_ctrl), .otg_ctrl(otg_ctrl),
        .pwr_ctrl(pwr_ctrl)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic do_write(input logic ext, input logic [7:0] a, input logic [7:0] d);
        acc_ext = ext; acc_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_read(input logic ext, input logic [7:0] a, output logic [7:0] d);
        acc_ext = ext; acc_addr = a; rd_en = 1'b1;
        @(negedge clk);
        d = rd_data;
        checks++;
        if (rd_valid !== 1'b1) begin
            failures++;
            $display("FAIL R11 actual=%0b expected=1 (rd_valid)", rd_valid);
        end
        rd_en = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state at the ports; R11 no valid without a strobe
        check("R1 func", func_ctrl, 8'h00);
        check("R1 pwr", pwr_ctrl, 8'h00);
        check("R11 idle valid", {7'd0, rd_valid}, 8'h00);

        for (int i = 0; i < NV; i++) begin
            logic [29:0] e;
            e = VEC[i];
            if (e[25]) begin
                do_read(e[24], e[23:16], v);
                checks++;
                if (v !== e[7:0]) begin
                    failures++;
                    $display("FAIL R%0d vec %0d actual=%02h expected=%02h", e[29:26], i, v, e[7:0]);
                end
            end else begin
                do_write(e[24], e[23:16], e[15:8]);
            end
        end

        // R13 outputs mirror the registers
        check("R13 func_ctrl", func_ctrl, 8'h5A);
        check("R13 intf_ctrl", intf_ctrl, 8'h30);
        check("R13 otg_ctrl", otg_ctrl, 8'h81);
        check("R13 pwr_ctrl", pwr_ctrl, 8'h13);

        // R6 debug byte
        line_state = 2'b10;
        do_read(1'b0, 8'h15, v);
        check("R6 line state", v, 8'h02);

        // R9 edge latch: src0 rise enabled, src1 fall enabled
        do_write(1'b0, 8'h0D, 8'h01);
        do_write(1'b0, 8'h10, 8'h02);
        irq_src = 5'b00011;
        do_read(1'b0, 8'h13, v);
        check("R6 irq status", v, 8'h03);
        do_read(1'b0, 8'h14, v);
        check("R9 rise enabled only", v, 8'h01);
        do_read(1'b0, 8'h14, v);
        check("R10 cleared by read", v, 8'h00);
        irq_src = 5'b00001;
        @(negedge clk);
        do_read(1'b0, 8'h14, v);
        check("R9 fall enabled", v, 8'h02);
        irq_src = 5'b00000;
        @(negedge clk);
        do_read(1'b0, 8'h14, v);
        check("R9 disabled fall", v, 8'h00);

        // R10 event in the same cycle as the clearing read
        irq_src = 5'b00001;
        do_read(1'b0, 8'h14, v);
        check("R10 same-cycle read", v, 8'h00);
        do_read(1'b0, 8'h14, v);
        check("R10 event kept", v, 8'h01);

        // R12 read and write together
        acc_ext = 1'b0; acc_addr = 8'h04; wr_data = 8'hC3; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        check("R12 old value", rd_data, 8'h5A);
        wr_en = 1'b0; rd_en = 1'b0;
        do_read(1'b0, 8'h04, v);
        check("R12 new value", v, 8'hC3);

        // R11 valid is a pulse and data holds
        @(negedge clk);
        check("R11 valid drops", {7'd0, rd_valid}, 8'h00);
        check("R11 data held", rd_data, 8'hC3);

        // R1 reset clears registers again
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 func after reset", func_ctrl, 8'h00);
        do_read(1'b0, 8'h0D, v);
        check("R1 enable after reset", v, 8'h00);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule